// File: doc/BRIEF.md
# Signed Number Format Converter

This block re-encodes an N-bit signed integer from one of three binary encodings into another. The three encodings are sign-magnitude, one's complement and two's complement. Each request carries a word, a source encoding code and a destination encoding code, and is qualified by a valid strobe. One clock later the block presents the re-encoded word together with two flags. The first flag marks an input that was a negative zero. The second marks a two's complement minimum that cannot be written in either of the other two encodings.

Inside, the input is split into a sign and an (N)-bit magnitude. The sign of a negative zero is cleared, and the pair is then rebuilt in the destination encoding. When the source and destination encodings match, the input word bypasses this path and is copied as it is. All outputs are registered and cleared by a synchronous active-high reset. The width is a parameter, and the bench runs at 4 bits so that every input can be covered.

Top module: `sfc_top`

## Requirements
- R1: Encoding codes on `src_fmt` and `dst_fmt` are 0 = sign-magnitude, 1 = one's complement, 2 = two's complement, and code 3 behaves exactly like code 2. In all three encodings bit N-1 is the sign. In sign-magnitude, bits N-2..0 are the magnitude. In one's complement, a negative value is the bitwise inverse of its positive. In two's complement, a negative value is 2^N minus its magnitude.
- R2: For any input whose value exists in the destination encoding, `out_word` carries the same integer value in the destination encoding. Zero is always written as all-zeros.
- R3: When source and destination map to the same encoding, `out_word` equals `in_word` bit for bit. This includes negative-zero patterns.
- R4: An input of 1 followed by zeros in sign-magnitude, or all-ones in one's complement, raises `out_negzero`. When the destination encoding differs from the source, `out_word` is all-zeros.
- R5: A two's complement input of 1 followed by zeros, sent to sign-magnitude or one's complement, raises `out_unrep` and forces `out_word` to zero. The same input sent to two's complement raises no flag.
- R6: A request with `in_valid` high appears on the outputs with `out_valid` high after exactly one rising clock edge.
- R7: A cycle with `in_valid` low gives `out_valid` low on the next edge. `out_word`, `out_negzero` and `out_unrep` keep their previous values.
- R8: `rst` high at a rising edge clears `out_valid`, `out_word`, `out_negzero` and `out_unrep` to zero.
- R9: `out_negzero` and `out_unrep` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_word | input | WIDTH | Word to convert |
| src_fmt | input | 2 | Encoding of `in_word` |
| dst_fmt | input | 2 | Encoding wanted on `out_word` |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_word | output | WIDTH | Converted word |
| out_negzero | output | 1 | Input was a negative zero |
| out_unrep | output | 1 | Input has no equivalent in the destination encoding |

## Verification
The assertions check the cycle-level rules on every clock:
- the one-cycle latency and the holding of outputs while idle;
- the clearing done by reset;
- the zero data forced under both flags;
- the mutual exclusion of the flags.

Whether a converted word carries the right value can only be shown by the bench's scenarios. These are a table of hand-picked corner conversions and an exhaustive sweep of every 4-bit word over every source and destination pair, each compared against an integer-valued reference. The sweep also covers the mapping of the reserved code 3.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    ENC_SM = 2'd0,
    ENC_OC = 2'd1,
    ENC_TC = 2'd2
  } enc_e;

  // Code 3 is folded onto two's complement.
  function automatic enc_e enc_norm(input logic [1:0] code);
    case (code)
      2'd0:    enc_norm = ENC_SM;
      2'd1:    enc_norm = ENC_OC;
      default: enc_norm = ENC_TC;
    endcase
  endfunction

endpackage

// File: rtl/sfc_decode.sv
module sfc_decode
  import sfc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] word,
  input  enc_e             enc,
  output logic             sign,
  output logic [WIDTH-1:0] mag,
  output logic             neg_zero,
  output logic             tc_min
);
  localparam int LW = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [LW-1:0] low;

  // Two's complement negate: invert and add one.
  function automatic logic [WIDTH-1:0] tc_negate(input logic [WIDTH-1:0] v);
    tc_negate = (~v) + ONE;
  endfunction

  assign low  = word[LW-1:0];
  assign sign = word[WIDTH-1];

  always_comb begin
    case (enc)
      ENC_SM:  mag = {1'b0, low};
      ENC_OC:  mag = sign ? {1'b0, ~low} : {1'b0, low};
      default: mag = sign ? tc_negate(word) : word;
    endcase
  end

  assign neg_zero = sign && (mag == '0) && (enc != ENC_TC);
  assign tc_min   = (enc == ENC_TC) && sign && (low == '0);

endmodule

// File: rtl/sfc_encode.sv
module sfc_encode
  import sfc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             sign,
  input  logic [WIDTH-1:0] mag,
  input  enc_e             enc,
  output logic [WIDTH-1:0] word
);
  localparam int LW = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [LW-1:0] mlow;
  assign mlow = mag[LW-1:0];

  always_comb begin
    case (enc)
      ENC_SM:  word = {sign, mlow};
      ENC_OC:  word = sign ? ~{1'b0, mlow} : {1'b0, mlow};
      default: word = sign ? ((~mag) + ONE) : mag;
    endcase
  end

endmodule

// File: rtl/sfc_top.sv
module sfc_top
  import sfc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_word,
  input  logic [1:0]       src_fmt,
  input  logic [1:0]       dst_fmt,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_word,
  output logic             out_negzero,
  output logic             out_unrep
);
  enc_e             src_enc, dst_enc;
  logic             dec_sign, dec_negzero, dec_tcmin;
  logic [WIDTH-1:0] dec_mag, enc_word;
  logic             pass_thru, sign_clean, unrep_now;
  logic [WIDTH-1:0] next_word;

  assign src_enc = enc_norm(src_fmt);
  assign dst_enc = enc_norm(dst_fmt);
  assign pass_thru = (src_enc == dst_enc);

  sfc_decode #(.WIDTH(WIDTH)) u_dec (
    .word     (in_word),
    .enc      (src_enc),
    .sign     (dec_sign),
    .mag      (dec_mag),
    .neg_zero (dec_negzero),
    .tc_min   (dec_tcmin)
  );

  // A negative zero loses its sign before re-encoding.
  assign sign_clean = dec_sign && !dec_negzero;

  sfc_encode #(.WIDTH(WIDTH)) u_enc (
    .sign (sign_clean),
    .mag  (dec_mag),
    .enc  (dst_enc),
    .word (enc_word)
  );

  assign unrep_now = dec_tcmin && !pass_thru;

  always_comb begin
    if (pass_thru)      next_word = in_word;
    else if (unrep_now) next_word = '0;
    else                next_word = enc_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_negzero <= 1'b0;
      out_unrep   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word    <= next_word;
        out_negzero <= dec_negzero;
        out_unrep   <= unrep_now;
      end
    end
  end

  // R6
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_negzero) && $stable(out_unrep)));

  // R8
  reset_clr_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_word == '0 && !out_negzero && !out_unrep));

  // R5
  unrep_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_unrep |-> (out_word == '0));

  // R4
  negzero_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_negzero && !pass_thru) |=> (out_word == '0 && out_negzero));

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_negzero && out_unrep));

endmodule

// File: tb/test_sfc_top.sv
module test_sfc_top;
  localparam int W = 4;
  localparam int NT = 9;
  // {src[1:0], dst[1:0], word[3:0], expected[3:0], 2'b00, negzero, unrep}
  localparam logic [15:0] TABLE [NT] = '{
    {2'd0, 2'd2, 4'hB, 4'hD, 2'b00, 1'b0, 1'b0},
    {2'd1, 2'd0, 4'hC, 4'hB, 2'b00, 1'b0, 1'b0},
    {2'd2, 2'd0, 4'h8, 4'h0, 2'b00, 1'b0, 1'b1},
    {2'd2, 2'd1, 4'h8, 4'h0, 2'b00, 1'b0, 1'b1},
    {2'd0, 2'd2, 4'h8, 4'h0, 2'b00, 1'b1, 1'b0},
    {2'd1, 2'd0, 4'hF, 4'h0, 2'b00, 1'b1, 1'b0},
    {2'd1, 2'd1, 4'hF, 4'hF, 2'b00, 1'b1, 1'b0},
    {2'd2, 2'd1, 4'h9, 4'h8, 2'b00, 1'b0, 1'b0},
    {2'd3, 2'd0, 4'hF, 4'h9, 2'b00, 1'b0, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_word = '0;
  logic [1:0]   src_fmt = 2'd0, dst_fmt = 2'd0;
  logic         out_valid, out_negzero, out_unrep;
  logic [W-1:0] out_word;
  int           n_chk = 0, n_bad = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  sfc_top #(.WIDTH(W)) i_sfc_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .src_fmt(src_fmt), .dst_fmt(dst_fmt), .out_valid(out_valid),
    .out_word(out_word), .out_negzero(out_negzero), .out_unrep(out_unrep)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Integer value of a word in an encoding (code 3 as two's complement).
  function automatic int value_of(input int code, input int w);
    int m;
    m = w & 7;
    if (code == 0) return (w >= 8) ? -m : m;
    if (code == 1) return (w >= 8) ? w - 15 : w;
    return (w >= 8) ? w - 16 : w;
  endfunction

  function automatic int word_of(input int code, input int v);
    if (v >= 0) return v;
    if (code == 0) return 8 + (-v);
    if (code == 1) return 15 + v;
    return 16 + v;
  endfunction

  task automatic request(input int s, input int d, input int w);
    @(negedge clk);
    in_valid = 1'b1; src_fmt = s[1:0]; dst_fmt = d[1:0]; in_word = w[W-1:0];
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 valid", out_valid, 0);
    check("R8 word", out_word, 0);
    check("R8 flags", {out_negzero, out_unrep}, 0);
    rst = 1'b0;

    for (int i = 0; i < NT; i++) begin
      request(TABLE[i][15:14], TABLE[i][13:12], TABLE[i][11:8]);
      check("R6 table valid", out_valid, 1);
      check("R2 R4 R5 table word", out_word, TABLE[i][7:4]);
      check("R4 table negzero", out_negzero, TABLE[i][1]);
      check("R5 table unrep", out_unrep, TABLE[i][0]);
    end

    // Exhaustive sweep, codes 0..3 on both sides (R1 R2 R3 R9)
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        for (int w = 0; w < 16; w++) begin
          int se, de, ew, v;
          bit nz, un;
          se = (s == 3) ? 2 : s;
          de = (d == 3) ? 2 : d;
          nz = (se == 0 && w == 8) || (se == 1 && w == 15);
          un = (se == 2 && w == 8 && de != 2);
          v  = value_of(se, w);
          if (se == de) ew = w;
          else if (un) ew = 0;
          else ew = word_of(de, v);
          request(s, d, w);
          check(se == de ? "R3 pass" : "R1 R2 convert", out_word, ew);
          check("R4 negzero", out_negzero, nz);
          check("R5 unrep", out_unrep, un);
          check("R9 exclusive", out_negzero & out_unrep, 0);
        end

    // R7: idle cycles with changing inputs keep outputs
    request(0, 2, 8);   // leaves word 0, negzero 1
    @(negedge clk);
    in_word = 4'h5; src_fmt = 2'd2; dst_fmt = 2'd0;
    @(negedge clk);
    check("R7 valid low", out_valid, 0);
    check("R7 word held", out_word, 0);
    check("R7 negzero held", out_negzero, 1);

    // R8 reset mid-run
    request(2, 0, 8);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R8 word cleared", out_word, 0);
    check("R8 unrep cleared", out_unrep, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule